// File: doc/BRIEF.md
# Dual-Loop Power and Lock Indicator Controller

This block decides which parts of a two-loop frequency synthesizer are powered: loop 1, loop 2 and the reference buffer that both loops share. Two external run pins act directly, through a short synchronizer. A small set of serial power bits is captured only when a strobe rises. The pins have priority. When both pins are high, the captured serial bits choose the power state.

The block also drives an open-drain lock indicator. A captured 2-bit select chooses which loop's lock flag is reported. The block outputs an active-low pull-down request, and the pad releases the line whenever that request is high. A loop that is powered down never counts as unlocked.

A two-state configuration machine tracks whether any setting has been captured since reset. The states are `CFG_EMPTY` (reset state; the serial path is forced off) and `CFG_LOADED`. There is one transition, named `first_load`, from `CFG_EMPTY` to `CFG_LOADED`, taken on the first strobe rise. `CFG_LOADED` then holds until reset.

Top module: `pwr_lock_ctrl`

## Requirements
- R1: When both synchronized run pins are low, `en_l1_o`, `en_l2_o` and `en_ref_o` are all 0, whatever the serial bits hold.
- R2: Run pin 1 low with pin 2 high gives loop 2 and buffer on and loop 1 off. Pin 1 high with pin 2 low gives loop 1 and buffer on and loop 2 off.
- R3: With both pins high and a configuration loaded, the captured bits (l1, l2, ref) select the enables. Bits 000 turn everything off. Bits 001 turn on the buffer only. Bits 01x turn on loop 2 and the buffer. Bits 10x turn on loop 1 and the buffer. Bits 11x turn everything on.
- R4: A run-pin level present at one rising clock edge reaches the enables right after the next rising edge.
- R5: The serial bits and the select are captured at a rising clock edge where `strobe_i` is 1 and was 0 at the previous edge. The enables reflect the captured values right after that edge. At any other edge, changes on these inputs have no effect.
- R6: In state `CFG_EMPTY` with both pins high, all enables are 0.
- R7: Select 00 keeps `lock_pull_n_o` at 0 (line pulled low).
- R8: With select 01 (report loop 2) or 10 (report loop 1), `lock_pull_n_o` is 0 exactly when the reported loop is enabled and its lock flag is 0.
- R9: With select 11, `lock_pull_n_o` is 0 exactly when some enabled loop has its lock flag at 0. It is 1 when both loops are disabled.
- R10: After reset, all enables are 0, the select is 00 and `lock_pull_n_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_run1_i | input | 1 | Asynchronous run pin for loop 1 |
| ext_run2_i | input | 1 | Asynchronous run pin for loop 2 |
| strobe_i | input | 1 | Capture strobe, synchronous to clk |
| cfg_l1_i | input | 1 | Serial power bit for loop 1 |
| cfg_l2_i | input | 1 | Serial power bit for loop 2 |
| cfg_ref_i | input | 1 | Serial power bit for the reference buffer |
| cfg_lsel_i | input | 2 | Lock report select; bit 1 = loop 1, bit 0 = loop 2 |
| lock1_i | input | 1 | Raw lock flag of loop 1 (1 = locked) |
| lock2_i | input | 1 | Raw lock flag of loop 2 (1 = locked) |
| en_l1_o | output | 1 | Loop 1 enable |
| en_l2_o | output | 1 | Loop 2 enable |
| en_ref_o | output | 1 | Reference buffer enable |
| lock_pull_n_o | output | 1 | 0 requests a pull-down of the lock line |

## Verification
The assertions assume that `strobe_i`, the serial bits and the lock flags are synchronous to the clock. Only the run pins may change at arbitrary times. The bench therefore drives every input on the falling clock edge, so nothing changes near the sampling edge.

The stimulus holds the strobe high across several edges to show that only a rising transition captures. It changes the serial bits while the strobe is idle, and it toggles the run pins at random intervals so that enable changes from the pins and from the strobe both occur.

// File: rtl/plc_pkg.sv
package plc_pkg;

    typedef enum logic [0:0] {
        CFG_EMPTY  = 1'b0,
        CFG_LOADED = 1'b1
    } cfg_state_e;

    typedef struct packed {
        logic       pwr_l1;
        logic       pwr_l2;
        logic       pwr_refb;
        logic [1:0] lsel;
    } serial_cfg_t;

    typedef struct packed {
        logic l1;
        logic l2;
        logic refb;
    } pwr_en_t;

    localparam serial_cfg_t CFG_RESET = '0;
    localparam pwr_en_t     EN_NONE   = '0;

endpackage

// File: rtl/plc_sync.sv
module plc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[LAST];
endmodule

// File: rtl/plc_cfg_latch.sv
module plc_cfg_latch
    import plc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        strobe_i,
    input  serial_cfg_t cfg_i,
    output serial_cfg_t cfg_o,
    output logic        loaded_o,
    output logic        strobe_rise_o
);
    cfg_state_e  state_q, state_d;
    serial_cfg_t cfg_q;
    logic        strobe_q;
    logic        rise;

    assign rise = strobe_i & ~strobe_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CFG_EMPTY;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_EMPTY:  if (rise) state_d = CFG_LOADED; // first_load
            CFG_LOADED: state_d = CFG_LOADED;
        endcase
    end

    // outputs
    always_comb begin
        loaded_o = 1'b0;
        unique case (state_q)
            CFG_EMPTY:  loaded_o = 1'b0;
            CFG_LOADED: loaded_o = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            cfg_q    <= CFG_RESET;
        end else begin
            strobe_q <= strobe_i;
            if (rise) cfg_q <= cfg_i;
        end
    end

    assign cfg_o         = cfg_q;
    assign strobe_rise_o = rise;
endmodule

// File: rtl/plc_power_merge.sv
module plc_power_merge
    import plc_pkg::*;
(
    input  logic [1:0]  run_i,     // [0] loop 1 pin, [1] loop 2 pin
    input  logic        loaded_i,
    input  serial_cfg_t cfg_i,
    output pwr_en_t     en_o
);
    pwr_en_t serial_en;

    always_comb begin
        serial_en = EN_NONE;
        if (loaded_i) begin
            unique case ({cfg_i.pwr_l1, cfg_i.pwr_l2})
                2'b00: serial_en = '{l1: 1'b0, l2: 1'b0, refb: cfg_i.pwr_refb};
                2'b01: serial_en = '{l1: 1'b0, l2: 1'b1, refb: 1'b1};
                2'b10: serial_en = '{l1: 1'b1, l2: 1'b0, refb: 1'b1};
                2'b11: serial_en = '{l1: 1'b1, l2: 1'b1, refb: 1'b1};
            endcase
        end
    end

    always_comb begin
        en_o = EN_NONE;
        unique case (run_i)
            2'b00: en_o = EN_NONE;
            2'b01: en_o = '{l1: 1'b1, l2: 1'b0, refb: 1'b1};
            2'b10: en_o = '{l1: 1'b0, l2: 1'b1, refb: 1'b1};
            2'b11: en_o = serial_en;
        endcase
    end
endmodule

// File: rtl/plc_lock_sel.sv
module plc_lock_sel
    import plc_pkg::*;
(
    input  pwr_en_t    en_i,
    input  logic [1:0] lsel_i,   // [1] loop 1, [0] loop 2
    input  logic       lock1_i,
    input  logic       lock2_i,
    output logic       pull_n_o
);
    logic unlock1, unlock2;

    assign unlock1 = en_i.l1 & ~lock1_i;
    assign unlock2 = en_i.l2 & ~lock2_i;

    always_comb begin
        pull_n_o = 1'b0;
        unique case (lsel_i)
            2'b00: pull_n_o = 1'b0;
            2'b01: pull_n_o = ~unlock2;
            2'b10: pull_n_o = ~unlock1;
            2'b11: pull_n_o = ~(unlock1 | unlock2);
        endcase
    end
endmodule

// File: rtl/pwr_lock_ctrl.sv
module pwr_lock_ctrl
    import plc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_run1_i,
    input  logic       ext_run2_i,
    input  logic       strobe_i,
    input  logic       cfg_l1_i,
    input  logic       cfg_l2_i,
    input  logic       cfg_ref_i,
    input  logic [1:0] cfg_lsel_i,
    input  logic       lock1_i,
    input  logic       lock2_i,
    output logic       en_l1_o,
    output logic       en_l2_o,
    output logic       en_ref_o,
    output logic       lock_pull_n_o
);
    localparam int RUN_W = 2;

    logic [RUN_W-1:0] run_sync;
    serial_cfg_t      cfg_in, cfg_q;
    logic             cfg_loaded;
    logic             strobe_rise;
    pwr_en_t          en;

    assign cfg_in = '{pwr_l1: cfg_l1_i, pwr_l2: cfg_l2_i,
                      pwr_refb: cfg_ref_i, lsel: cfg_lsel_i};

    plc_sync #(.WIDTH(RUN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ext_run2_i, ext_run1_i}),
        .sync_o  (run_sync)
    );

    plc_cfg_latch u_cfg (
        .clk           (clk),
        .rst_n         (rst_n),
        .strobe_i      (strobe_i),
        .cfg_i         (cfg_in),
        .cfg_o         (cfg_q),
        .loaded_o      (cfg_loaded),
        .strobe_rise_o (strobe_rise)
    );

    plc_power_merge u_merge (
        .run_i    (run_sync),
        .loaded_i (cfg_loaded),
        .cfg_i    (cfg_q),
        .en_o     (en)
    );

    plc_lock_sel u_lock (
        .en_i     (en),
        .lsel_i   (cfg_q.lsel),
        .lock1_i  (lock1_i),
        .lock2_i  (lock2_i),
        .pull_n_o (lock_pull_n_o)
    );

    assign en_l1_o  = en.l1;
    assign en_l2_o  = en.l2;
    assign en_ref_o = en.refb;
endmodule

// File: rtl/plc_checker.sv
module plc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] run_sync,
    input logic       loaded,
    input logic       strobe_rise,
    input logic [1:0] lsel,
    input logic       en_l1_o,
    input logic       en_l2_o,
    input logic       en_ref_o,
    input logic       lock_pull_n_o
);
    assert_all_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run_sync == 2'b00) |-> (!en_l1_o && !en_l2_o && !en_ref_o));

    assert_pin2_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_sync == 2'b10) |-> (!en_l1_o && en_l2_o && en_ref_o));

    assert_pin1_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_sync == 2'b01) |-> (en_l1_o && !en_l2_o && en_ref_o));

    assert_loop_needs_buffer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_l1_o || en_l2_o) |-> en_ref_o);

    assert_hold_between_strobes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({en_l1_o, en_l2_o, en_ref_o}) |-> (!$stable(run_sync) || $past(strobe_rise)));

    assert_empty_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_sync == 2'b11 && !loaded) |-> (!en_l1_o && !en_l2_o && !en_ref_o));

    assert_sel_zero_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lsel == 2'b00) |-> !lock_pull_n_o);

    assert_released_when_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lsel != 2'b00 && !en_l1_o && !en_l2_o) |-> lock_pull_n_o);
endmodule

bind pwr_lock_ctrl plc_checker u_plc_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .run_sync      (run_sync),
    .loaded        (cfg_loaded),
    .strobe_rise   (strobe_rise),
    .lsel          (cfg_q.lsel),
    .en_l1_o       (en_l1_o),
    .en_l2_o       (en_l2_o),
    .en_ref_o      (en_ref_o),
    .lock_pull_n_o (lock_pull_n_o)
);

// File: tb/test_pwr_lock_ctrl.sv
module test_pwr_lock_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_run1_i = 1'b0, ext_run2_i = 1'b0, strobe_i = 1'b0;
    logic       cfg_l1_i = 1'b0, cfg_l2_i = 1'b0, cfg_ref_i = 1'b0;
    logic [1:0] cfg_lsel_i = 2'b00;
    logic       lock1_i = 1'b0, lock2_i = 1'b0;
    logic       en_l1_o, en_l2_o, en_ref_o, lock_pull_n_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    pwr_lock_ctrl i_pwr_lock_ctrl (
        .clk, .rst_n, .ext_run1_i, .ext_run2_i, .strobe_i,
        .cfg_l1_i, .cfg_l2_i, .cfg_ref_i, .cfg_lsel_i,
        .lock1_i, .lock2_i,
        .en_l1_o, .en_l2_o, .en_ref_o, .lock_pull_n_o
    );

    // reference model state
    logic [1:0] pin_hist[$];     // newest first, {pin2, pin1}
    bit   m_loaded, m_prev_strb, m_rose;
    bit   m_b1, m_b2, m_bref;
    logic [1:0] m_sel;

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_hist = '{2'b00, 2'b00, 2'b00};
            m_loaded = 0; m_prev_strb = 0; m_rose = 0;
            m_b1 = 0; m_b2 = 0; m_bref = 0; m_sel = 2'b00;
        end else begin
            cycles++;
            pin_hist.push_front({ext_run2_i, ext_run1_i});
            if (pin_hist.size() > 3) void'(pin_hist.pop_back());
            m_rose = strobe_i && !m_prev_strb;
            if (m_rose) begin
                m_b1 = cfg_l1_i; m_b2 = cfg_l2_i; m_bref = cfg_ref_i;
                m_sel = cfg_lsel_i; m_loaded = 1;
            end
            m_prev_strb = strobe_i;
        end
    end

    // compare 5 ns after every rising edge
    always @(posedge clk) begin
        #5;
        if (rst_n && !done) begin
            bit e1, e2, er, ep;
            string tag, ltag;
            logic [1:0] p;
            p = pin_hist[1];
            e1 = 0; e2 = 0; er = 0;
            if (p == 2'b00) tag = "R1";
            else if (p == 2'b01) begin e1 = 1; er = 1; tag = "R2"; end
            else if (p == 2'b10) begin e2 = 1; er = 1; tag = "R2"; end
            else if (!m_loaded) tag = "R6";
            else begin
                tag = "R3";
                if (m_b1 || m_b2) begin e1 = m_b1; e2 = m_b2; er = 1; end
                else er = m_bref;
            end
            if (m_rose) tag = {tag, "/R5"};
            else if (pin_hist[1] != pin_hist[2]) tag = {tag, "/R4"};
            chk(tag, "en_l1", en_l1_o, e1);
            chk(tag, "en_l2", en_l2_o, e2);
            chk(tag, "en_ref", en_ref_o, er);
            case (m_sel)
                2'b00: begin ep = 0; ltag = "R7"; end
                2'b01: begin ep = !(e2 && !lock2_i); ltag = "R8"; end
                2'b10: begin ep = !(e1 && !lock1_i); ltag = "R8"; end
                default: begin ep = !((e1 && !lock1_i) || (e2 && !lock2_i)); ltag = "R9"; end
            endcase
            chk(ltag, "lock_pull_n", lock_pull_n_o, ep);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R10: reset state
        step(2);
        chk("R10", "en_l1 in reset", en_l1_o, 1'b0);
        chk("R10", "en_l2 in reset", en_l2_o, 1'b0);
        chk("R10", "en_ref in reset", en_ref_o, 1'b0);
        chk("R10", "lock_pull_n in reset", lock_pull_n_o, 1'b0);
        rst_n = 1'b1;
        // R6: pins high, serial bits set but no strobe yet
        ext_run1_i = 1; ext_run2_i = 1;
        cfg_l1_i = 1; cfg_l2_i = 1; cfg_ref_i = 1; cfg_lsel_i = 2'b11;
        step(8);
        // R5: long strobe pulse, bits change while held high
        strobe_i = 1; step(1);
        cfg_l1_i = 0; cfg_l2_i = 0; cfg_ref_i = 0; cfg_lsel_i = 2'b01;
        step(5);
        strobe_i = 0; step(4);
        // R3 table sweep with both pins high
        for (int v = 0; v < 8; v++) begin
            {cfg_l1_i, cfg_l2_i, cfg_ref_i} = v[2:0];
            cfg_lsel_i = v[1:0];
            strobe_i = 1; step(1);
            strobe_i = 0;
            for (int k = 0; k < 4; k++) begin
                {lock1_i, lock2_i} = k[1:0];
                step(1);
            end
        end
        // R4/R1/R2: pin sweeps
        for (int v = 0; v < 4; v++) begin
            {ext_run2_i, ext_run1_i} = v[1:0];
            step(4);
        end
        // random mix
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(7) == 0) {ext_run2_i, ext_run1_i} = 2'($urandom_range(3));
            if ($urandom_range(3) == 0) begin
                {cfg_l1_i, cfg_l2_i, cfg_ref_i} = 3'($urandom_range(7));
                cfg_lsel_i = 2'($urandom_range(3));
            end
            strobe_i = ($urandom_range(4) == 0);
            {lock1_i, lock2_i} = 2'($urandom_range(3));
            step(1);
        end
        step(3);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule